// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 1M bytes. The host asks for one byte at a time with a request strobe, a write flag, a 20-bit address and write data. The block then produces the memory's pin activity: a low-true and a high-true chip enable, a low-true write strobe, a low-true output enable, the address bus and a tri-stated 8-bit data bus. Each access ends with a one-clock completion pulse. On a read, the fetched byte appears on the read data port in the same cycle as that pulse.

Each phase length is a whole number of clock cycles. The block gets it by dividing the memory's nanosecond minimums by the clock period parameter and rounding up. A grade parameter switches between the 70 ns and the 100 ns timing sets. The block drives the data bus only while the write strobe is low. After a read it holds off any write drive until the memory has had time to release the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset, and whenever `busy` is low, the memory is deselected (`mem_ce_n`=1, `mem_ce`=0), `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq` is not driven.
- R2: A read holds the memory selected with `mem_we_n`=1 and `mem_oe_n`=0 for exactly RD cycles. RD is the ceiling of max(cycle time, address access, output-enable access) over the clock period, which is 14 at 5 ns for the 70 ns grade. `mem_addr` carries the requested address throughout.
- R3: On the clock edge that ends the read phase, `rdata` takes the value on `mem_dq`. `mem_oe_n` rises at that same edge.
- R4: A write has one setup cycle, selected with `mem_we_n`=1 and `mem_oe_n`=1, followed by exactly WP cycles of `mem_we_n`=0. WP is the maximum of ceil(35/T), ceil(30/T), ceil(70/T)-1 and ceil(70/T)-1, which is 13 at T=5 ns. `mem_dq` carries the write data and is driven only while `mem_we_n`=0.
- R5: `mem_addr` changes only while `mem_we_n` is high, and it stays stable throughout a write strobe.
- R6: After `mem_oe_n` rises, the block does not drive `mem_dq` for at least TA cycles. TA is ceil(max(35,30)/T), which is 7 at 5 ns. A write requested sooner than that waits, deselected and busy.
- R7: `busy` is high from the cycle after a request is accepted until the block is back in idle. A request made while `busy` is high is ignored and produces no memory activity.
- R8: `done` is high for exactly one cycle per access, in the cycle right after the access's last strobe cycle.
- R9: With the 100 ns grade selected at 5 ns, the read phase lasts 20 cycles and the write strobe lasts 19 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled while idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Last read data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| mem_ce_n | output | 1 | Low-true chip enable |
| mem_ce | output | 1 | High-true chip enable |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_addr | output | 20 | Memory address bus |
| mem_dq | inout | 8 | Memory data bus |

## Verification
The assertions check the following on every cycle:
- the idle pin state;
- that the output enable and the write strobe are asserted only while the memory is selected;
- that the bus is driven only inside the strobe;
- that the address is stable around the strobe;
- the turnaround spacing, measured with a separate counter;
- that completion is a single pulse.

Only the bench's scenarios can show the remaining properties:
- exact phase lengths for both grades;
- that the correct byte lands in memory and comes back;
- that a request made while busy leaves memory untouched;
- that a write issued right after a read is delayed.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int CLK_NS     = 5,
  parameter bit SLOW_GRADE = 1'b0,
  parameter int AW         = 20,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          busy,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_dq
);
  function automatic int cyc(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_ACC  = SLOW_GRADE ? 100 : 70;
  localparam int T_OEA  = SLOW_GRADE ? 50 : 35;
  localparam int T_WPW  = SLOW_GRADE ? 50 : 35;
  localparam int T_DSU  = SLOW_GRADE ? 40 : 30;
  localparam int T_OFF  = SLOW_GRADE ? 35 : 30;
  localparam int T_DSEL = SLOW_GRADE ? 40 : 35;
  localparam int RD_CYC = imax(cyc(T_ACC), cyc(T_OEA));
  localparam int WP_CYC = imax(imax(cyc(T_WPW), cyc(T_DSU)), imax(cyc(T_ACC) - 1, 1));
  localparam int TA_CYC = imax(cyc(T_OFF), cyc(T_DSEL));
  localparam int CW     = $clog2(imax(RD_CYC, WP_CYC) + 1);
  localparam int GW     = $clog2(TA_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WWAIT, S_WSET, S_WPULSE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [GW-1:0] guard;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          sel, dq_oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      guard   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (guard != 0) guard <= guard - 1'b1;
      case (st)
        S_IDLE: if (req) begin
          addr_q  <= addr;
          wdata_q <= wdata;
          if (!wr) begin
            st  <= S_READ;
            cnt <= CW'(RD_CYC - 1);
          end else begin
            st <= (guard != 0) ? S_WWAIT : S_WSET;
          end
        end
        S_READ: if (cnt == 0) begin
          rdata <= mem_dq;
          done  <= 1'b1;
          guard <= GW'(TA_CYC);
          st    <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WWAIT: if (guard == 0) st <= S_WSET;
        S_WSET: begin
          st  <= S_WPULSE;
          cnt <= CW'(WP_CYC - 1);
        end
        S_WPULSE: if (cnt == 0) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel      = (st == S_READ) || (st == S_WSET) || (st == S_WPULSE);
  assign dq_oe    = (st == S_WPULSE);
  assign busy     = (st != S_IDLE);
  assign mem_ce_n = !sel;
  assign mem_ce   = sel;
  assign mem_oe_n = (st != S_READ);
  assign mem_we_n = !dq_oe;
  assign mem_addr = addr_q;
  assign mem_dq   = dq_oe ? wdata_q : {DW{1'bz}};

  logic [GW-1:0] oe_quiet;
  always_ff @(posedge clk) begin
    if (!rst_n) oe_quiet <= GW'(TA_CYC);
    else if (!mem_oe_n) oe_quiet <= '0;
    else if (oe_quiet < GW'(TA_CYC)) oe_quiet <= oe_quiet + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !dq_oe));
  assert_read_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_ce && mem_we_n));
  assert_drive_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!mem_we_n && mem_oe_n && !mem_ce_n && mem_ce));
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
  assert_addr_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> (mem_we_n && $past(mem_we_n)));
  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (oe_quiet >= GW'(TA_CYC)));
  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!mem_oe_n) || $past(!mem_we_n)));
endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        done, busy, mem_ce_n, mem_ce, mem_we_n, mem_oe_n;
  logic [19:0] mem_addr;
  wire  [7:0]  dq;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .busy(busy), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq(dq));

  logic        s_req = 1'b0, s_wr = 1'b0;
  logic [7:0]  s_rdata;
  logic        s_done, s_busy, s_ce_n, s_ce, s_we_n, s_oe_n;
  logic [19:0] s_maddr;
  wire  [7:0]  s_dq;

  sram_async_ctrl #(.SLOW_GRADE(1'b1)) dut_slow (
    .clk(clk), .rst_n(rst_n), .req(s_req), .wr(s_wr), .addr(20'h00123), .wdata(8'h3C),
    .rdata(s_rdata), .done(s_done), .busy(s_busy), .mem_ce_n(s_ce_n), .mem_ce(s_ce),
    .mem_we_n(s_we_n), .mem_oe_n(s_oe_n), .mem_addr(s_maddr), .mem_dq(s_dq));

  // Memory model
  logic [7:0] sram    [bit [19:0]];
  logic [7:0] ref_mem [bit [19:0]];
  logic       m_drv = 1'b0;
  logic [7:0] m_q = '0;
  assign dq = m_drv ? m_q : 8'hzz;
  wire msel = !mem_ce_n && mem_ce;

  int oe_run = 0, oe_last = 0, we_run = 0, we_last = 0, pre = 0, we_pre = 0;
  int since_rd = 1000, gap_at_we = 1000, done_cnt = 0;
  int s_oe_run = 0, s_oe_last = 0, s_we_run = 0, s_we_last = 0;
  logic [19:0] rd_addr_seen = '0, wr_addr_seen = '0;
  logic [7:0]  dq_seen = '0;
  bit          addr_moved = 1'b0;

  always @(negedge clk) begin
    if (msel && !mem_we_n) sram[mem_addr] = dq;
    m_drv = msel && !mem_oe_n && mem_we_n;
    m_q   = sram.exists(mem_addr) ? sram[mem_addr] : 8'h00;
    if (!mem_oe_n) begin oe_run++; rd_addr_seen = mem_addr; end
    else if (oe_run != 0) begin oe_last = oe_run; oe_run = 0; end
    if (!mem_we_n) begin
      if (we_run == 0) begin we_pre = pre; gap_at_we = since_rd; wr_addr_seen = mem_addr; end
      else if (mem_addr != wr_addr_seen) addr_moved = 1'b1;
      we_run++; dq_seen = dq;
    end else if (we_run != 0) begin we_last = we_run; we_run = 0; end
    if (msel && mem_we_n && mem_oe_n) pre++; else if (!msel) pre = 0;
    if (!mem_oe_n) since_rd = 0; else if (since_rd < 1000) since_rd++;
    if (done) done_cnt++;
    if (!s_oe_n) s_oe_run++; else if (s_oe_run != 0) begin s_oe_last = s_oe_run; s_oe_run = 0; end
    if (!s_we_n) s_we_run++; else if (s_we_run != 0) begin s_we_last = s_we_run; s_we_run = 0; end
  end

  int checks = 0, failures = 0;
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask
  task automatic tick();
    @(negedge clk); #1;
  endtask

  function automatic int cdiv(int ns, int p);
    return (ns + p - 1) / p;
  endfunction
  function automatic int mx(int a, int b);
    return a > b ? a : b;
  endfunction
  localparam int TCK = 5;
  int exp_rd, exp_wp, exp_ta;

  bit prev_read = 1'b0;
  localparam logic [19:0] POKE_A = 20'h77777;

  task automatic check_idle(string tag);
    chk({tag, " R1 ce_n"}, mem_ce_n, 1);
    chk({tag, " R1 ce"}, mem_ce, 0);
    chk({tag, " R1 we_n"}, mem_we_n, 1);
    chk({tag, " R1 oe_n"}, mem_oe_n, 1);
    chk({tag, " R7 busy"}, busy, 0);
  endtask

  task automatic access(bit w, logic [19:0] a, logic [7:0] d, bit poke);
    int dc0, n;
    logic [7:0] expv;
    n = 0;
    while (busy) tick();
    dc0 = done_cnt;
    req = 1'b1; wr = w; addr = a; wdata = d;
    tick();
    req = 1'b0;
    chk("R7 busy after accept", busy, 1);
    if (poke) begin
      tick(); tick();
      req = 1'b1; wr = 1'b1; addr = POKE_A; wdata = 8'h5A;
      tick();
      req = 1'b0;
    end
    while (done_cnt == dc0 && n < 500) begin tick(); n++; end
    if (n >= 500) chk("R8 done timeout", 0, 1);
    if (w) begin
      ref_mem[a] = d;
      chk("R4 WE-low cycles", we_last, exp_wp);
      chk("R4 setup cycle", we_pre, 1);
      chk("R4 driven data", dq_seen, d);
      chk("R4 stored byte", sram.exists(a) ? sram[a] : -1, d);
      chk("R5 address under strobe", wr_addr_seen, a);
      chk("R5 address stable", addr_moved, 0);
      if (prev_read) chk("R6 turnaround held", gap_at_we >= exp_ta, 1);
    end else begin
      expv = ref_mem.exists(a) ? ref_mem[a] : 8'h00;
      chk("R2 OE-low cycles", oe_last, exp_rd);
      chk("R2 read address", rd_addr_seen, a);
      chk("R3 read data", rdata, expv);
    end
    prev_read = !w;
    tick(); tick();
    chk("R8 single done", done_cnt - dc0, 1);
    chk("R8 done low", done, 0);
    check_idle("post");
    if (poke) chk("R7 ignored request", sram.exists(POKE_A), 0);
  endtask

  logic [19:0] pool [8];

  initial begin
    #(TCK * 190000);
    failures++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int dc;
    void'($urandom(32'd20240607));
    exp_rd = mx(cdiv(70, TCK), cdiv(35, TCK));
    exp_wp = mx(mx(cdiv(35, TCK), cdiv(30, TCK)), cdiv(70, TCK) - 1);
    exp_ta = mx(cdiv(35, TCK), cdiv(30, TCK));
    for (int i = 0; i < 8; i++) pool[i] = 20'($urandom) & 20'hFFF0F;
    pool[0] = 20'h00000; pool[1] = 20'hFFFFF;
    repeat (4) tick();
    check_idle("reset");
    chk("R8 reset done", done, 0);
    rst_n = 1'b1;
    tick();
    check_idle("after reset");

    access(1'b0, 20'h00055, 8'h00, 1'b0);          // R3 unwritten reads zero
    access(1'b1, 20'h00000, 8'hA5, 1'b0);          // R4 lowest address
    access(1'b1, 20'hFFFFF, 8'h5A, 1'b0);          // R4 highest address
    access(1'b0, 20'h00000, 8'h00, 1'b0);
    access(1'b1, 20'h12345, 8'hC3, 1'b0);          // R6 write right after read
    access(1'b0, 20'hFFFFF, 8'h00, 1'b0);
    access(1'b1, 20'h00ABC, 8'h81, 1'b1);          // R7 request while busy
    access(1'b0, 20'h00ABC, 8'h00, 1'b1);
    for (int k = 0; k < 60; k++) begin
      access(1'($urandom), pool[$urandom % 8], 8'($urandom), (k % 10) == 3);
    end

    // R9: slow grade phase lengths
    s_req = 1'b1; s_wr = 1'b1; tick(); s_req = 1'b0;
    dc = 0; while (!s_done && dc < 200) begin tick(); dc++; end
    tick();
    chk("R9 slow WE-low cycles", s_we_last, cdiv(100, TCK) - 1);
    s_req = 1'b1; s_wr = 1'b0; tick(); s_req = 1'b0;
    dc = 0; while (!s_done && dc < 200) begin tick(); dc++; end
    tick();
    chk("R9 slow OE-low cycles", s_oe_last, cdiv(100, TCK));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule